// File: doc/BRIEF.md
# Wide-to-Narrow Memory-Mapped Bridge

This block sits between a 32-bit memory-mapped master and a 16-bit memory-mapped slave. Each master access becomes an ordered pair of half-word slave accesses, or a single one when only one half of the word is enabled. The master's byte enables decide which halves are needed. The slave byte enables for each half are taken straight from the matching 2-bit slice of the master's byte enables.

On a write, the low half-word goes to the slave first and the high half-word goes second. On a read, the low half-word is captured and held. It is then joined with the high half-word, and the 32-bit result is returned with a one-cycle valid pulse. The master is held by a wait-request until the last slave transfer of the sequence is accepted. Any slave wait-request stretches the transfer that is in progress.

The master address is a byte address. The two bits below the 32-bit word boundary are ignored, because the byte enables select the lanes. The slave address is a half-word address, which is the master byte address divided by two, with its lowest bit selecting the half.

Top module: `w2n_bridge`

## Requirements
- R1: A write with all four byte enables set produces two slave writes. The first carries master data bits 15:0 and the second carries bits 31:16.
- R2: For every slave transfer, the slave byte enable equals `mByteEn[1:0]` when the low half is sent and `mByteEn[3:2]` when the high half is sent.
- R3: When only one half has any byte enable set, exactly one slave transfer is issued, for that half only.
- R4: The slave address of a transfer is `{mAddr[ADDR_W-1:2], h}`, where h is 0 for the low half and 1 for the high half. The second transfer of a pair uses 2N+1 when the first used 2N. `mAddr[1:0]` have no effect.
- R5: A read asserts `mReadDataValid` for exactly one cycle, in the cycle after the access completes. `mReadData` holds the high slave half-word in bits 31:16 and the low one in bits 15:0.
- R6: A read with only one half enabled returns zero in the other half of `mReadData`.
- R7: `mWaitReq` is high for every cycle of a request except the one in which the last slave transfer is accepted. Each slave transfer is held while `sWaitReq` is high.
- R8: An access with all byte enables clear completes in one cycle with no slave transfer. If it is a read, it returns zero with a valid pulse.
- R9: During reset, `sRead`, `sWrite` and `mReadDataValid` are low.
- R10: `sRead` and `sWrite` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| mAddr | input | ADDR_W | Master byte address |
| mRead | input | 1 | Master read request, held while mWaitReq is high |
| mWrite | input | 1 | Master write request, held while mWaitReq is high |
| mByteEn | input | WIDE_W/8 | Master byte enables |
| mWriteData | input | WIDE_W | Master write data |
| mWaitReq | output | 1 | Stall to the master |
| mReadData | output | WIDE_W | Assembled read word |
| mReadDataValid | output | 1 | One-cycle read data strobe |
| sAddr | output | ADDR_W-1 | Slave half-word address |
| sRead | output | 1 | Slave read strobe |
| sWrite | output | 1 | Slave write strobe |
| sByteEn | output | NARROW_W/8 | Slave byte enables |
| sWriteData | output | NARROW_W | Slave write data |
| sReadData | input | NARROW_W | Slave read data, valid in the accepting cycle |
| sWaitReq | input | 1 | Stall from the slave |

## Verification
The bench records every accepted slave transfer and compares the count, order, address, byte enables and data with values it works out from the master's byte enables.

The corner cases are these:
- Single-half accesses. A bridge that always sent both halves would leave a lone extra transfer in the log.
- High-half-only accesses. Sending the wrong half would show up as an even address where an odd one belongs.
- Zero byte enables. Here a bridge that waited for a slave acceptance would hang the master.
- Random slave stalls placed on the first and on the second transfer. A bridge that latched the low half at the wrong moment, or released the master early, would return a corrupted read word or a cycle count that does not match the number of transfers plus the number of stalls.

// File: rtl/w2n_pkg.sv
package w2n_pkg;

  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } w2nPhase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic issue;       // a slave transfer is presented this cycle
    logic upperSel;    // the presented transfer is the high half
    logic latchLo;     // capture low read half (accepted, high half pending)
    logic finishRead;  // read sequence completes this cycle
  } w2nStrobe_t;

endpackage

// File: rtl/w2n_ctrl.sv
module w2n_ctrl
  import w2n_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       mRead,
  input  logic       mWrite,
  input  logic       loNeed,
  input  logic       hiNeed,
  input  logic       sWaitReq,
  output logic       sRead,
  output logic       sWrite,
  output logic       mWaitReq,
  output w2nStrobe_t strobe
);

  w2nPhase_t phase;
  w2nPhase_t phaseNext;
  logic request;
  logic readOp;
  logic finish;

  always_comb begin
    request   = mRead | mWrite;
    readOp    = mRead & ~mWrite;
    strobe    = '0;
    finish    = 1'b0;
    phaseNext = phase;
    if (request) begin
      case (phase)
        PH_FIRST: begin
          if (!loNeed && !hiNeed) begin
            finish = 1'b1;
          end else begin
            strobe.issue    = 1'b1;
            strobe.upperSel = ~loNeed;
            if (!sWaitReq) begin
              if (loNeed && hiNeed) begin
                strobe.latchLo = 1'b1;
                phaseNext      = PH_SECOND;
              end else begin
                finish = 1'b1;
              end
            end
          end
        end
        PH_SECOND: begin
          strobe.issue    = 1'b1;
          strobe.upperSel = 1'b1;
          if (!sWaitReq) begin
            finish    = 1'b1;
            phaseNext = PH_FIRST;
          end
        end
        default: phaseNext = PH_FIRST;
      endcase
    end
    strobe.finishRead = finish & readOp;
    mWaitReq = request & ~finish;
    sWrite   = strobe.issue & mWrite;
    sRead    = strobe.issue & readOp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_FIRST;
    else       phase <= phaseNext;
  end

endmodule

// File: rtl/w2n_datapath.sv
module w2n_datapath
  import w2n_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  w2nStrobe_t            strobe,
  input  logic [ADDR_W-1:0]     mAddr,
  input  logic [WIDE_W/8-1:0]   mByteEn,
  input  logic [WIDE_W-1:0]     mWriteData,
  input  logic [NARROW_W-1:0]   sReadData,
  output logic [ADDR_W-2:0]     sAddr,
  output logic [NARROW_W/8-1:0] sByteEn,
  output logic [NARROW_W-1:0]   sWriteData,
  output logic [WIDE_W-1:0]     mReadData,
  output logic                  mReadDataValid
);

  localparam int NB      = NARROW_W / 8;
  localparam int WORD_LSB = $clog2(WIDE_W / 8);

  logic [NARROW_W-1:0] wrHalf [2];
  logic [NB-1:0]       beHalf [2];
  logic [NARROW_W-1:0] loHeld;
  logic [WIDE_W-1:0]   readWord;
  logic                unusedAddrBits;

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign wrHalf[h] = mWriteData[h*NARROW_W +: NARROW_W];
    assign beHalf[h] = mByteEn[h*NB +: NB];
  end

  assign unusedAddrBits = ^mAddr[WORD_LSB-1:0];
  assign sAddr      = {mAddr[ADDR_W-1:WORD_LSB], strobe.upperSel};
  assign sByteEn    = strobe.upperSel ? beHalf[1] : beHalf[0];
  assign sWriteData = strobe.upperSel ? wrHalf[1] : wrHalf[0];

  always_comb begin
    if (!strobe.issue)
      readWord = '0;
    else if (strobe.upperSel)
      readWord = {sReadData, (|beHalf[0]) ? loHeld : {NARROW_W{1'b0}}};
    else
      readWord = {{NARROW_W{1'b0}}, sReadData};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loHeld         <= '0;
      mReadData      <= '0;
      mReadDataValid <= 1'b0;
    end else begin
      if (strobe.latchLo) loHeld <= sReadData;
      if (strobe.finishRead) mReadData <= readWord;
      mReadDataValid <= strobe.finishRead;
    end
  end

endmodule

// File: rtl/w2n_bridge.sv
module w2n_bridge
  import w2n_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     mAddr,
  input  logic                  mRead,
  input  logic                  mWrite,
  input  logic [WIDE_W/8-1:0]   mByteEn,
  input  logic [WIDE_W-1:0]     mWriteData,
  output logic                  mWaitReq,
  output logic [WIDE_W-1:0]     mReadData,
  output logic                  mReadDataValid,
  output logic [ADDR_W-2:0]     sAddr,
  output logic                  sRead,
  output logic                  sWrite,
  output logic [NARROW_W/8-1:0] sByteEn,
  output logic [NARROW_W-1:0]   sWriteData,
  input  logic [NARROW_W-1:0]   sReadData,
  input  logic                  sWaitReq
);

  localparam int NB = NARROW_W / 8;

  w2nStrobe_t strobe;
  logic loNeed;
  logic hiNeed;

  assign loNeed = |mByteEn[NB-1:0];
  assign hiNeed = |mByteEn[2*NB-1:NB];

  w2n_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .mRead    (mRead),
    .mWrite   (mWrite),
    .loNeed   (loNeed),
    .hiNeed   (hiNeed),
    .sWaitReq (sWaitReq),
    .sRead    (sRead),
    .sWrite   (sWrite),
    .mWaitReq (mWaitReq),
    .strobe   (strobe)
  );

  w2n_datapath #(
    .ADDR_W   (ADDR_W),
    .WIDE_W   (WIDE_W),
    .NARROW_W (NARROW_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .mAddr          (mAddr),
    .mByteEn        (mByteEn),
    .mWriteData     (mWriteData),
    .sReadData      (sReadData),
    .sAddr          (sAddr),
    .sByteEn        (sByteEn),
    .sWriteData     (sWriteData),
    .mReadData      (mReadData),
    .mReadDataValid (mReadDataValid)
  );

endmodule

// File: rtl/w2n_bridge_chk.sv
module w2n_bridge_chk #(
  parameter int ADDR_W   = 16,
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [ADDR_W-1:0]     mAddr,
  input logic [WIDE_W/8-1:0]   mByteEn,
  input logic                  mRead,
  input logic                  mWaitReq,
  input logic                  mReadDataValid,
  input logic [ADDR_W-2:0]     sAddr,
  input logic [NARROW_W/8-1:0] sByteEn,
  input logic                  sRead,
  input logic                  sWrite,
  input logic                  sWaitReq
);

  localparam int NB   = NARROW_W / 8;
  localparam int SA_W = ADDR_W - 1;

  // R10
  excl_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sRead && sWrite));

  // R2
  lo_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((sRead || sWrite) && !sAddr[0]) |-> sByteEn == mByteEn[NB-1:0]);

  // R3
  live_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sRead || sWrite) |-> sByteEn != '0);

  // R4
  word_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sRead || sWrite) |-> sAddr[SA_W-1:1] == mAddr[ADDR_W-1:2]);

  // R1
  hi_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sWrite && !sAddr[0] && !sWaitReq && (mByteEn[2*NB-1:NB] != '0))
      |=> (sWrite && sAddr[0] && sAddr[SA_W-1:1] == $past(sAddr[SA_W-1:1])));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((sRead || sWrite) && sWaitReq) |-> mWaitReq);

  // R5
  valid_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    mReadDataValid |-> $past(mRead && !mWaitReq));

endmodule

bind w2n_bridge w2n_bridge_chk #(
  .ADDR_W   (ADDR_W),
  .WIDE_W   (WIDE_W),
  .NARROW_W (NARROW_W)
) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .mAddr          (mAddr),
  .mByteEn        (mByteEn),
  .mRead          (mRead),
  .mWaitReq       (mWaitReq),
  .mReadDataValid (mReadDataValid),
  .sAddr          (sAddr),
  .sByteEn        (sByteEn),
  .sRead          (sRead),
  .sWrite         (sWrite),
  .sWaitReq       (sWaitReq)
);

// File: tb/w2n_bridge_test.sv
module w2n_bridge_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] mAddr = '0;
  logic        mRead = 1'b0;
  logic        mWrite = 1'b0;
  logic [3:0]  mByteEn = '0;
  logic [31:0] mWriteData = '0;
  logic        mWaitReq;
  logic [31:0] mReadData;
  logic        mReadDataValid;
  logic [14:0] sAddr;
  logic        sRead;
  logic        sWrite;
  logic [1:0]  sByteEn;
  logic [15:0] sWriteData;
  logic [15:0] sReadData;
  logic        sWaitReq = 1'b0;

  int total = 0;
  int fails = 0;
  int stallPct = 0;

  logic [15:0] sMem [64];
  logic [31:0] refMem [32];
  logic [14:0] logAddr [4];
  logic [1:0]  logBe [4];
  logic [15:0] logData [4];
  int logN = 0;
  int stallN = 0;
  int validN = 0;
  int bothSeen = 0;

  always #10 clk = ~clk;

  w2n_bridge uut (
    .clk(clk), .rstN(rstN), .mAddr(mAddr), .mRead(mRead), .mWrite(mWrite),
    .mByteEn(mByteEn), .mWriteData(mWriteData), .mWaitReq(mWaitReq),
    .mReadData(mReadData), .mReadDataValid(mReadDataValid), .sAddr(sAddr),
    .sRead(sRead), .sWrite(sWrite), .sByteEn(sByteEn), .sWriteData(sWriteData),
    .sReadData(sReadData), .sWaitReq(sWaitReq)
  );

  // slave model: data valid in the accepting cycle
  assign sReadData = sMem[sAddr[5:0]];

  always @(posedge clk) begin
    if (sRead && sWrite) bothSeen <= bothSeen + 1;
    if (mReadDataValid) validN <= validN + 1;
    if ((sRead || sWrite) && sWaitReq) stallN <= stallN + 1;
    if ((sRead || sWrite) && !sWaitReq) begin
      if (logN < 4) begin
        logAddr[logN] <= sAddr;
        logBe[logN]   <= sByteEn;
        logData[logN] <= sWriteData;
      end
      logN <= logN + 1;
      if (sWrite) begin
        for (int b = 0; b < 2; b++)
          if (sByteEn[b]) sMem[sAddr[5:0]][b*8 +: 8] <= sWriteData[b*8 +: 8];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] laneMask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] halfMask(input logic [3:0] be);
    return {{16{|be[3:2]}}, {16{|be[1:0]}}};
  endfunction

  task automatic access(input bit wr, input logic [15:0] a, input logic [3:0] be,
                        input logic [31:0] d);
    int cyc;
    bit done;
    int n;
    bit lo;
    bit hi;
    logic [31:0] expRd;
    lo = |be[1:0];
    hi = |be[3:2];
    n  = int'(lo) + int'(hi);
    expRd = refMem[a[6:2]] & halfMask(be);
    @(negedge clk);
    logN = 0; stallN = 0; validN = 0;
    mAddr = a; mByteEn = be; mWriteData = d;
    mWrite = wr; mRead = !wr;
    cyc = 0;
    while (1) begin
      sWaitReq = (($urandom % 100) < stallPct);
      #2;
      done = !mWaitReq;
      cyc++;
      @(posedge clk);
      if (done || cyc > 200) break;
      @(negedge clk);
    end
    @(negedge clk);
    mRead = 1'b0; mWrite = 1'b0; sWaitReq = 1'b0;
    chk(n == 0 ? "R8 transfer count" : (n == 1 ? "R3 transfer count" : "R1 transfer count"),
        logN, n);
    chk("R7 request cycles", cyc, (n == 0) ? 1 : n + stallN);
    for (int i = 0; i < logN && i < 2; i++) begin
      bit h;
      h = (i == 0 && lo) ? 1'b0 : 1'b1;
      chk("R4 slave address", {17'b0, logAddr[i]}, {17'b0, a[15:2], h});
      chk("R2 slave byte enable", {30'b0, logBe[i]}, {30'b0, h ? be[3:2] : be[1:0]});
      if (wr) chk("R1 slave write data", {16'b0, logData[i]}, {16'b0, h ? d[31:16] : d[15:0]});
    end
    if (!wr) begin
      chk("R5 valid after completion", {31'b0, mReadDataValid}, 32'd1);
      chk(halfMask(be) == 32'hFFFF_FFFF ? "R5 read word" : "R6 read word", mReadData, expRd);
      @(negedge clk);
      chk("R5 single valid pulse", validN, 1);
    end else begin
      refMem[a[6:2]] = (refMem[a[6:2]] & ~laneMask(be)) | (d & laneMask(be));
      chk("R5 no valid on write", validN, 0);
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) sMem[i] = '0;
    for (int i = 0; i < 32; i++) refMem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R9 sRead in reset", {31'b0, sRead}, 0);
    chk("R9 sWrite in reset", {31'b0, sWrite}, 0);
    chk("R9 valid in reset", {31'b0, mReadDataValid}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // directed, no stalls
    access(1'b1, 16'h0010, 4'b1111, 32'h1234_5678);
    access(1'b0, 16'h0010, 4'b1111, '0);
    access(1'b1, 16'h0020, 4'b0011, 32'hAAAA_BEEF);
    access(1'b1, 16'h0023, 4'b1100, 32'hCAFE_5555);   // R4: low address bits ignored
    access(1'b0, 16'h0020, 4'b1100, '0);
    access(1'b0, 16'h0021, 4'b0011, '0);
    access(1'b1, 16'h0030, 4'b0100, 32'h0077_0000);
    access(1'b1, 16'h0030, 4'b0000, 32'hFFFF_FFFF);   // R8
    access(1'b0, 16'h0030, 4'b0000, '0);              // R8
    access(1'b0, 16'h0030, 4'b1111, '0);
    // directed with stalls
    stallPct = 60;
    access(1'b1, 16'h0044, 4'b1111, 32'h0BAD_F00D);
    access(1'b0, 16'h0044, 4'b1111, '0);
    access(1'b0, 16'h0044, 4'b1000, '0);
    // random
    for (int k = 0; k < 400; k++) begin
      stallPct = $urandom % 70;
      access(($urandom % 2) == 1, 16'($urandom % 128), 4'($urandom), $urandom);
    end
    chk("R10 read and write never together", bothSeen, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule